// File: doc/BRIEF.md
# Recursive-Network Next-Hop Selector

This block decides, for one router of a recursively built network, which output port a packet leaves by on its next hop. The network is built from fully connected basic modules of `NUM_DIGIT_VALUES` nodes, nested `NUM_LEVELS` deep. A node address is a string of base-`NUM_DIGIT_VALUES` digits, one per level. A packet's route is fixed by three things: the digit prefixes the current node and the destination share, and the runs of repeated low digits in the current address.

Each clock, the router presents the address of the node the packet is at and the address of its destination. One cycle later the block returns a port number. That port is one of three kinds: local eject, a link to a sibling inside the same basic module, or the node's single link that bridges two subnetworks. It also returns a flag that marks a bridging hop. The downstream virtual-channel logic uses this flag to move the packet to the next channel class. Buffering, switching, arbitration and channel allocation belong to other blocks.

Top module: `wkr_route`

## Requirements
- R1: While `rst` is high, and after it is released with no request yet, `rsp_valid`, `rsp_port` and `rsp_flip` are all 0.
- R2: `rsp_valid` equals `req_valid` from the previous cycle. In a cycle with `req_valid` low, `rsp_port` and `rsp_flip` keep their values whatever the address inputs carry.
- R3: When the two addresses are equal, the response is port 0 (local eject) with `rsp_flip` low.
- R4: The digit of level k occupies bits [(k-1)*DW +: DW] of an address, with DW = ceil(log2(NUM_DIGIT_VALUES)). Port 0 is eject. Ports 1 to NUM_DIGIT_VALUES-1 reach the sibling nodes whose lowest digit is g, taken in increasing g with the node's own lowest digit skipped: port g+1 for g below the own digit, port g otherwise. Port NUM_DIGIT_VALUES is the bridging link.
- R5: When the addresses differ only in the level-1 digit, the response is the sibling port toward the destination's level-1 digit.
- R6: Let i > 1 be the highest level where the addresses differ, and v the destination's digit at level i. If the current node's level-1 digit is not v, the response is the sibling port toward digit v.
- R7: Under the condition of R6, if the current node's level-1 digit equals v, the response is the bridging port NUM_DIGIT_VALUES.
- R8: `rsp_flip` is high exactly when `rsp_port` equals NUM_DIGIT_VALUES.
- R9: The bridging port is never chosen for a node whose digits are all equal, since that node's bridging link is left open.
- R10: Take any source and destination, and step along the chosen ports, where the bridging link from a node whose lowest k digits equal y and whose level-(k+1) digit is x replaces those k+1 digits by y followed by k copies of x. The walk reaches the destination, and asks for eject there, within 2^NUM_LEVELS - 1 hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A route request is presented this cycle |
| req_here | input | NUM_LEVELS*DW | Address of the node the packet is at |
| req_dest | input | NUM_LEVELS*DW | Destination address |
| rsp_valid | output | 1 | Response carries the result of last cycle's request |
| rsp_port | output | clog2(NUM_DIGIT_VALUES+1) | Chosen output port |
| rsp_flip | output | 1 | Chosen hop crosses a bridging link |

## Verification
The bench builds the block with three digit values per level and three levels. This gives a 27-node network in which digits do not fill their two-bit field, and whose longest route takes all seven hops. At that size every source and destination pair can be walked hop by hop through a topology model written from the adjacency rules alone. This exposes any wrong port as a route that loops, leaves through an open link, or overruns the hop limit. Directed cases pin down sibling ports on either side of the node's own digit and bridging at both the middle and the top level.

// File: rtl/wkr_pkg.sv
package wkr_pkg;

    typedef enum logic [1:0] {
        HOP_EJECT = 2'd0,
        HOP_SUBST = 2'd1,
        HOP_FLIP  = 2'd2
    } hop_kind_e;

    // Sibling port number for target lowest digit, skipping the own digit.
    function automatic int subst_port_num(input int own_digit, input int tgt_digit);
        return (tgt_digit < own_digit) ? tgt_digit + 1 : tgt_digit;
    endfunction

endpackage

// File: rtl/wkr_top_diff.sv
module wkr_top_diff #(
    parameter int D = 4,
    parameter int T = 3
) (
    input  logic [T*((D > 2) ? $clog2(D) : 1)-1:0] here,
    input  logic [T*((D > 2) ? $clog2(D) : 1)-1:0] dest,
    output logic                                  diff_found,
    output logic [((T > 1) ? $clog2(T) : 1)-1:0]  diff_lvl,
    output logic [((D > 2) ? $clog2(D) : 1)-1:0]  diff_dest_digit
);
    localparam int DW = (D > 2) ? $clog2(D) : 1;
    localparam int LW = (T > 1) ? $clog2(T) : 1;

    logic [T-1:0] neq;

    for (genvar g = 0; g < T; g++) begin : g_cmp
        assign neq[g] = (here[g*DW +: DW] != dest[g*DW +: DW]);
    end

    // Ascending scan: the highest differing level is the last one kept.
    always_comb begin
        diff_found      = |neq;
        diff_lvl        = '0;
        diff_dest_digit = dest[DW-1:0];
        for (int k = 0; k < T; k++) begin
            if (neq[k]) begin
                diff_lvl        = LW'(k);
                diff_dest_digit = dest[k*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/wkr_hop_pick.sv
module wkr_hop_pick
    import wkr_pkg::*;
#(
    parameter int D = 4,
    parameter int T = 3
) (
    input  logic                                  diff_found,
    input  logic [((T > 1) ? $clog2(T) : 1)-1:0]  diff_lvl,
    input  logic [((D > 2) ? $clog2(D) : 1)-1:0]  diff_dest_digit,
    input  logic [((D > 2) ? $clog2(D) : 1)-1:0]  here_low,
    input  logic [((D > 2) ? $clog2(D) : 1)-1:0]  dest_low,
    output hop_kind_e                             kind,
    output logic [$clog2(D+1)-1:0]                port,
    output logic                                  flip
);
    localparam int DW = (D > 2) ? $clog2(D) : 1;
    localparam int PW = $clog2(D+1);

    logic [DW-1:0] tgt_digit;

    // Above level 1 the whole recursive descent toward the bridging
    // frontier collapses to one test on the lowest digit.
    always_comb begin
        kind      = HOP_EJECT;
        tgt_digit = dest_low;
        if (!diff_found) begin
            kind = HOP_EJECT;
        end else if (diff_lvl == '0) begin
            kind      = HOP_SUBST;
            tgt_digit = dest_low;
        end else if (here_low != diff_dest_digit) begin
            kind      = HOP_SUBST;
            tgt_digit = diff_dest_digit;
        end else begin
            kind = HOP_FLIP;
        end
    end

    always_comb begin
        unique case (kind)
            HOP_SUBST: port = PW'(subst_port_num(int'(here_low), int'(tgt_digit)));
            HOP_FLIP:  port = PW'(D);
            default:   port = '0;
        endcase
    end

    assign flip = (kind == HOP_FLIP);

endmodule

// File: rtl/wkr_route.sv
module wkr_route
    import wkr_pkg::*;
#(
    parameter int NUM_DIGIT_VALUES = 4,
    parameter int NUM_LEVELS       = 3
) (
    input  logic                                                           clk,
    input  logic                                                           rst,
    input  logic                                                           req_valid,
    input  logic [NUM_LEVELS*((NUM_DIGIT_VALUES > 2) ? $clog2(NUM_DIGIT_VALUES) : 1)-1:0] req_here,
    input  logic [NUM_LEVELS*((NUM_DIGIT_VALUES > 2) ? $clog2(NUM_DIGIT_VALUES) : 1)-1:0] req_dest,
    output logic                                                           rsp_valid,
    output logic [$clog2(NUM_DIGIT_VALUES+1)-1:0]                          rsp_port,
    output logic                                                           rsp_flip
);
    localparam int DW = (NUM_DIGIT_VALUES > 2) ? $clog2(NUM_DIGIT_VALUES) : 1;
    localparam int LW = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
    localparam int PW = $clog2(NUM_DIGIT_VALUES+1);

    logic          diff_found;
    logic [LW-1:0] diff_lvl;
    logic [DW-1:0] diff_dest_digit;
    hop_kind_e     nxt_kind;
    logic [PW-1:0] nxt_port;
    logic          nxt_flip;

    wkr_top_diff #(.D(NUM_DIGIT_VALUES), .T(NUM_LEVELS)) diff_i (
        .here            (req_here),
        .dest            (req_dest),
        .diff_found      (diff_found),
        .diff_lvl        (diff_lvl),
        .diff_dest_digit (diff_dest_digit)
    );

    wkr_hop_pick #(.D(NUM_DIGIT_VALUES), .T(NUM_LEVELS)) pick_i (
        .diff_found      (diff_found),
        .diff_lvl        (diff_lvl),
        .diff_dest_digit (diff_dest_digit),
        .here_low        (req_here[DW-1:0]),
        .dest_low        (req_dest[DW-1:0]),
        .kind            (nxt_kind),
        .port            (nxt_port),
        .flip            (nxt_flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_port  <= '0;
            rsp_flip  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_port <= nxt_port;
                rsp_flip <= nxt_flip;
            end
        end
    end

endmodule

// File: rtl/wkr_route_chk.sv
module wkr_route_chk #(
    parameter int D = 4,
    parameter int T = 3
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  req_valid,
    input logic [T*((D > 2) ? $clog2(D) : 1)-1:0] req_here,
    input logic [T*((D > 2) ? $clog2(D) : 1)-1:0] req_dest,
    input logic                                  rsp_valid,
    input logic [$clog2(D+1)-1:0]                rsp_port,
    input logic                                  rsp_flip
);
    localparam int DW = (D > 2) ? $clog2(D) : 1;
    localparam int PW = $clog2(D+1);

    logic here_uniform;

    always_comb begin
        here_uniform = 1'b1;
        for (int k = 1; k < T; k++) begin
            if (req_here[k*DW +: DW] != req_here[DW-1:0]) here_uniform = 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !rsp_valid && rsp_port == '0 && !rsp_flip);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> rsp_valid == $past(req_valid));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !req_valid |=> $stable(rsp_port) && $stable(rsp_flip));

    // R3
    eject_same_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_here == req_dest |=> rsp_port == '0 && !rsp_flip);

    // R4
    port_range_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> rsp_port <= PW'(D));

    // R8
    flag_match_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> rsp_flip == (rsp_port == PW'(D)));

    // R9
    open_edge_chk: assert property (@(posedge clk) disable iff (rst) req_valid && here_uniform |=> !rsp_flip);

endmodule

bind wkr_route wkr_route_chk #(.D(NUM_DIGIT_VALUES), .T(NUM_LEVELS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_here  (req_here),
    .req_dest  (req_dest),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_flip  (rsp_flip)
);

// File: tb/wkr_route_tb.sv
module wkr_route_tb_top;
    localparam int D  = 3;
    localparam int T  = 3;
    localparam int DW = 2;
    localparam int AW = T*DW;
    localparam int PW = 2;
    localparam int NODES = D*D*D;
    localparam int MAX_HOPS = (1 << T) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_here = '0;
    logic [AW-1:0] req_dest = '0;
    logic          rsp_valid;
    logic [PW-1:0] rsp_port;
    logic          rsp_flip;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wkr_route #(.NUM_DIGIT_VALUES(D), .NUM_LEVELS(T)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_here(req_here), .req_dest(req_dest),
        .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_flip(rsp_flip)
    );

    function automatic int mk(input int a3, input int a2, input int a1);
        return a3*D*D + a2*D + a1;
    endfunction

    function automatic logic [AW-1:0] to_bits(input int a);
        logic [AW-1:0] r = '0;
        int v = a;
        for (int k = 0; k < T; k++) begin
            r[k*DW +: DW] = DW'(v % D);
            v = v / D;
        end
        return r;
    endfunction

    function automatic int digit_of(input int a, input int k);
        int v = a;
        for (int j = 0; j < k; j++) v = v / D;
        return v % D;
    endfunction

    function automatic int set_digit(input int a, input int k, input int val);
        int w = 1;
        for (int j = 0; j < k; j++) w = w * D;
        return a + (val - digit_of(a, k)) * w;
    endfunction

    // Neighbour reached through port p, from the adjacency rules; -1 if none.
    function automatic int nbr(input int a, input int p);
        int own, g, y, x, k, r;
        own = a % D;
        if (p >= 1 && p < D) begin
            g = (p - 1 < own) ? p - 1 : p;
            return set_digit(a, 0, g);
        end
        if (p != D) return -1;
        y = own;
        k = 0;
        while (k < T && digit_of(a, k) == y) k++;
        if (k == T) return -1;
        x = digit_of(a, k);
        r = set_digit(a, k, y);
        for (int j = 0; j < k; j++) r = set_digit(r, j, x);
        return r;
    endfunction

    int got_port;
    int got_flip;
    int got_valid;

    task automatic do_req(input int here, input int dest);
        @(negedge clk);
        req_here  = to_bits(here);
        req_dest  = to_bits(dest);
        req_valid = 1'b1;
        @(negedge clk);
        got_port  = int'(rsp_port);
        got_flip  = int'(rsp_flip);
        got_valid = int'(rsp_valid);
        req_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        check(rsp_valid == 1'b0, "R1 valid", int'(rsp_valid), 0);
        check(rsp_port == '0, "R1 port", int'(rsp_port), 0);
        check(rsp_flip == 1'b0, "R1 flip", int'(rsp_flip), 0);
    endtask

    task automatic t_hop(input string req, input int here, input int dest, input int exp_port);
        do_req(here, dest);
        check(got_valid == 1, {req, " valid"}, got_valid, 1);
        check(got_port == exp_port, {req, " port"}, got_port, exp_port);
        check(got_flip == ((exp_port == D) ? 1 : 0), {req, " R8 flip"}, got_flip, (exp_port == D) ? 1 : 0);
    endtask

    task automatic t_idle;
        do_req(mk(0,1,2), mk(0,2,0));
        @(negedge clk);
        req_here = to_bits(mk(1,1,1));
        req_dest = to_bits(mk(2,0,0));
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 idle valid", int'(rsp_valid), 0);
        check(int'(rsp_port) == D, "R2 idle port hold", int'(rsp_port), D);
        check(rsp_flip == 1'b1, "R2 idle flip hold", int'(rsp_flip), 1);
    endtask

    task automatic t_walk_all;
        for (int s = 0; s < NODES; s++) begin
            for (int t = 0; t < NODES; t++) begin
                int cur = s;
                int hops = 0;
                bit ok = 1'b1;
                bit arrived = 1'b0;
                while (!arrived && ok && hops <= MAX_HOPS) begin
                    do_req(cur, t);
                    if (got_flip != ((got_port == D) ? 1 : 0)) ok = 1'b0;
                    if (got_port == 0) begin
                        arrived = 1'b1;
                        if (cur != t) ok = 1'b0;
                    end else begin
                        cur = nbr(cur, got_port);
                        hops++;
                        if (cur < 0) ok = 1'b0;
                    end
                end
                check(ok && arrived && hops <= MAX_HOPS, "R10 walk", hops, MAX_HOPS);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hop("R3 eject", mk(0,1,2), mk(0,1,2), 0);
        t_hop("R5 up", mk(0,1,0), mk(0,1,2), 2);
        t_hop("R5 down", mk(0,1,2), mk(0,1,0), 1);
        t_hop("R6 mid", mk(0,1,1), mk(0,2,2), 2);
        t_hop("R6 top", mk(1,1,1), mk(2,0,0), 2);
        t_hop("R7 mid", mk(0,1,2), mk(0,2,0), D);
        t_hop("R7 top", mk(1,2,2), mk(2,1,1), D);
        t_hop("R9 uniform", mk(2,2,2), mk(0,0,0), 1);
        t_hop("R4 low own", mk(2,0,1), mk(2,0,0), 1);
        t_idle();
        t_walk_all();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule